// File: doc/BRIEF.md
# SPI Register Word Access Master

This block is an SPI master that performs one 16-bit register read or write on a radio transceiver whose register space is addressed with 6 bits. The host pulses a request while the block is idle and supplies the address, a read flag and the write data. The block then runs one fixed sequence. It masks two interrupt-enable bits in a host-side interrupt-enable register. It asserts an active-low chip enable and shifts out a command byte followed by two data bytes. It releases the chip enable, writes the saved interrupt-enable value back, and ends with a single-cycle done pulse.

The command byte carries the address in its low six bits and the read flag in bit 7. A read clocks out two zero bytes and assembles the two bytes that come back into the result word, high byte first. A write clocks out the high data byte and then the low data byte, and discards everything received. The SPI clock runs in mode 0. Each of its half periods is a parameter number of core clock cycles.

Top module: `spi_reg_word_master`

## Requirements
- R1: The first byte shifted out in a transaction is the command: bits 5:0 are addr_i, bit 6 is 0, and bit 7 is 1 for a read (rd_i=1) and 0 for a write.
- R2: For a write, the two bytes after the command are wdata_i[15:8] then wdata_i[7:0], and rdata_o keeps its previous value.
- R3: For a read, the two bytes after the command are 0x00. The first byte received after the command becomes rdata_o[15:8] and the second becomes rdata_o[7:0], both valid by the done pulse. The byte received during the command is discarded.
- R4: Bytes are shifted MSB first in mode 0. SCLK idles low and MOSI changes only while SCLK is low. MISO is sampled on the rising edge. Every SCLK high phase lasts exactly CLK_DIV clock cycles, and every low phase inside the frame lasts at least CLK_DIV cycles.
- R5: Each transaction gives exactly 24 SCLK rising edges, all with spi_cs_no low. spi_cs_no falls at least CLK_DIV cycles before the first rising edge and rises at least CLK_DIV cycles after the last falling edge. SCLK is low whenever spi_cs_no is high.
- R6: On acceptance the block captures irq_en_i. In the cycle before spi_cs_no falls, it writes (irq_en_we_o=1) the captured value with bits 1 and 2 cleared. In the cycle spi_cs_no rises, it writes the captured value unchanged. Each transaction makes exactly these two writes.
- R7: busy_o rises in the cycle after acceptance and stays high through the done cycle. done_o is high for one cycle, the cycle after the restoring write, and busy_o is low in the cycle that follows.
- R8: A request while busy_o is high is ignored: it starts no extra frame and does not change the bytes of the running transaction.
- R9: During reset, spi_cs_no is 1, SCLK is 0, busy_o, done_o and irq_en_we_o are 0, and rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only while idle |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read result |
| irq_en_i | input | 8 | Current interrupt-enable register value |
| irq_en_we_o | output | 1 | Write strobe for the interrupt-enable register |
| irq_en_o | output | 8 | Value to write to the interrupt-enable register |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | Chip enable, active low |
| spi_mosi_o | output | 1 | Master data out |
| spi_miso_i | input | 1 | Master data in |

## Verification
A wrong byte index or a wrong shift count shows up at the pins within one frame. The 24-bit MOSI capture of that transaction is corrupted, the edge count moves away from 24, or the result word comes back byte-swapped or shifted by the done pulse. A fault in the sequencer's phase order shows as a misplaced interrupt-enable write relative to the chip-enable edges, or as a done pulse off by a cycle. Both are measured against a cycle stamp in the same transaction. A broken capture of the saved interrupt-enable value shows in the restoring write, because the bench changes irq_en_i after acceptance.

// File: rtl/spi_rw_pkg.sv
package spi_rw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_RESTORE,
    ST_DONE
  } st_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned DIV = 4,
  parameter int unsigned BW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] tx_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          done_o,
  output logic [BW-1:0] rx_o
);
  localparam int unsigned BIT_W = $clog2(BW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BW - 1);

  logic            active_q;
  logic            sclk_q;
  logic            done_q;
  logic [BIT_W-1:0] bit_q;
  logic [BW-1:0]   tx_sh_q;
  logic [BW-1:0]   rx_sh_q;
  logic            tick;

  spi_half_timer #(.DIV(DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        bit_q    <= '0;
        tx_sh_q  <= tx_i;
      end else if (active_q && tick) begin
        if (!sclk_q) begin
          sclk_q  <= 1'b1;
          rx_sh_q <= {rx_sh_q[BW-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            tx_sh_q <= {tx_sh_q[BW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_sh_q[BW-1];
  assign done_o = done_q;
  assign rx_o   = rx_sh_q;

  // R4: output bit must not move during a high phase
  a_r4_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
  // R4: a byte is never restarted mid-flight
  a_r4_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/spi_irq_guard.sv
module spi_irq_guard #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   MASK = 8'h06
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         save_i,
  input  logic [W-1:0] irq_i,
  input  logic         mask_phase_i,
  input  logic         restore_phase_i,
  output logic         we_o,
  output logic [W-1:0] val_o
);
  logic [W-1:0] saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     saved_q <= '0;
    else if (save_i) saved_q <= irq_i;
  end

  assign we_o  = mask_phase_i || restore_phase_i;
  assign val_o = mask_phase_i ? (saved_q & ~MASK) : saved_q;
endmodule

// File: rtl/spi_reg_word_master.sv
module spi_reg_word_master
  import spi_rw_pkg::*;
#(
  parameter int unsigned    CLK_DIV  = 4,
  parameter int unsigned    ADDR_W   = 6,
  parameter int unsigned    DATA_W   = 16,
  parameter int unsigned    IRQ_W    = 8,
  parameter logic [IRQ_W-1:0] IRQ_MASK = 8'h06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IRQ_W-1:0]  irq_en_i,
  output logic              irq_en_we_o,
  output logic [IRQ_W-1:0]  irq_en_o,
  output logic              spi_sclk_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int unsigned NUM_DB = DATA_W / BYTE_W;
  localparam int unsigned IDX_W  = $clog2(NUM_DB + 1);
  localparam int unsigned PAD_W  = BYTE_W - 1 - ADDR_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DB);

  st_e               state_q, state_d;
  logic [BYTE_W-1:0] cmd_q;
  logic              rd_q;
  logic [DATA_W-1:0] wdata_sh_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] rdata_q;
  logic [IDX_W-1:0]  idx_q;

  logic              accept;
  logic              wait_tick;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_rx;
  logic              byte_start;
  logic [BYTE_W-1:0] byte_tx;
  logic              last_byte;

  assign accept    = req_i && (state_q == ST_IDLE);
  assign last_byte = (idx_q == LAST_IDX);

  spi_half_timer #(.DIV(CLK_DIV)) u_frame_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state_q == ST_SETUP) || (state_q == ST_HOLD)),
    .tick_o (wait_tick)
  );

  assign byte_start = ((state_q == ST_SETUP) && wait_tick) ||
                      ((state_q == ST_XFER) && byte_done && !last_byte);
  // data phase sends zeros on reads, next queued write byte otherwise
  assign byte_tx = (state_q == ST_SETUP) ? cmd_q :
                   (rd_q ? '0 : wdata_sh_q[DATA_W-1 -: BYTE_W]);

  spi_byte_shifter #(.DIV(CLK_DIV), .BW(BYTE_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (byte_start),
    .tx_i    (byte_tx),
    .miso_i  (spi_miso_i),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (byte_done),
    .rx_o    (byte_rx)
  );

  spi_irq_guard #(.W(IRQ_W), .MASK(IRQ_MASK)) u_irq_guard (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .save_i          (accept),
    .irq_i           (irq_en_i),
    .mask_phase_i    (state_q == ST_MASK),
    .restore_phase_i (state_q == ST_RESTORE),
    .we_o            (irq_en_we_o),
    .val_o           (irq_en_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_MASK;
      ST_MASK:    state_d = ST_SETUP;
      ST_SETUP:   if (wait_tick) state_d = ST_XFER;
      ST_XFER:    if (byte_done && last_byte) state_d = ST_HOLD;
      ST_HOLD:    if (wait_tick) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      rd_q       <= 1'b0;
      wdata_sh_q <= '0;
      acc_q      <= '0;
      rdata_q    <= '0;
      idx_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cmd_q      <= {rd_i, {PAD_W{1'b0}}, addr_i};
        rd_q       <= rd_i;
        wdata_sh_q <= wdata_i;
      end
      if (state_q == ST_SETUP) idx_q <= '0;
      if ((state_q == ST_XFER) && byte_done) begin
        if (!last_byte) begin
          idx_q      <= idx_q + 1'b1;
          wdata_sh_q <= {wdata_sh_q[DATA_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
        // command-phase byte is dropped; writes keep nothing
        if ((idx_q != '0) && rd_q) begin
          acc_q <= {acc_q[DATA_W-BYTE_W-1:0], byte_rx};
          if (last_byte) rdata_q <= {acc_q[DATA_W-BYTE_W-1:0], byte_rx};
        end
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign rdata_o   = rdata_q;
  assign spi_cs_no = !((state_q == ST_SETUP) || (state_q == ST_XFER) || (state_q == ST_HOLD));

  a_r5_sclk_low_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);
  a_r6_mask_before_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> $past(irq_en_we_o));
  a_r6_restore_on_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> irq_en_we_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r8_cmd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cmd_q));
endmodule

// File: tb/tb_spi_reg_word_master.sv
module tb_spi_reg_word_master;
  localparam int unsigned CLK_DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  irq_in = '0;
  logic        miso = 1'b0;
  logic        busy, done, we, sclk, cs_n, mosi;
  logic [15:0] rdata;
  logic [7:0]  irq_out;

  always #2 clk = ~clk;

  spi_reg_word_master #(.CLK_DIV(CLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .irq_en_i(irq_in), .irq_en_we_o(we), .irq_en_o(irq_out),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int checks = 0, fails = 0;
  int cyc = 0, edges_tot = 0, we_tot = 0, done_tot = 0, busy_tot = 0;
  int mask_cyc, restore_cyc, cs_fall_cyc, cs_rise_cyc, first_rise_cyc;
  int last_fall_cyc, last_edge_cyc, done_cyc, busy_rise_cyc;
  int bad_high = 0, mosi_viol = 0, sclk_cs_viol = 0, min_low = 1000;
  logic [7:0]  mask_val, restore_val;
  logic [23:0] mosi_sr = '0, miso_sr = '0, slave_pat = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_busy = 1'b0;
  bit first_pending = 0;

  // pin monitor and slave model
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      cs_fall_cyc = cyc; miso_sr = slave_pat; miso = miso_sr[23]; first_pending = 1;
    end
    if (!prev_cs && cs_n) cs_rise_cyc = cyc;
    if (!prev_sclk && sclk) begin
      edges_tot++;
      mosi_sr = {mosi_sr[22:0], mosi};
      if (first_pending) begin first_rise_cyc = cyc; first_pending = 0; end
      else if (cyc - last_edge_cyc < min_low) min_low = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
    end
    if (prev_sclk && !sclk) begin
      if (cyc - last_edge_cyc != CLK_DIV) bad_high++;
      last_edge_cyc = cyc; last_fall_cyc = cyc;
      miso_sr = {miso_sr[22:0], 1'b0}; miso = miso_sr[23];
    end
    if (prev_sclk && sclk && (mosi != prev_mosi)) mosi_viol++;
    if (sclk && cs_n) sclk_cs_viol++;
    if (we) begin
      if (we_tot % 2 == 0) begin mask_val = irq_out; mask_cyc = cyc; end
      else begin restore_val = irq_out; restore_cyc = cyc; end
      we_tot++;
    end
    if (done) begin done_tot++; done_cyc = cyc; end
    if (busy) busy_tot++;
    if (busy && !prev_busy) busy_rise_cyc = cyc;
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi; prev_busy = busy;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input logic r, input logic [5:0] a, input logic [15:0] wd,
                         input logic [7:0] irq, input logic [23:0] pat, input bit poke);
    int e0 = edges_tot, w0 = we_tot, d0 = done_tot, b0 = busy_tot;
    logic [15:0] rprev = rdata;
    logic [23:0] exp_mosi = {r, 1'b0, a, (r ? 16'h0000 : wd)};
    int tmo = 0;
    @(negedge clk);
    req = 1; rd = r; addr = a; wdata = wd; irq_in = irq; slave_pat = pat;
    @(negedge clk);
    req = 0; irq_in = ~irq;
    if (poke) begin
      repeat (5) @(negedge clk);
      req = 1; rd = ~r; addr = ~a; wdata = ~wd;
      @(negedge clk);
      req = 0;
    end
    while (done_tot == d0 && tmo < 2000) begin @(posedge clk); tmo++; end
    chk(tmo < 2000, "R7 timeout", tmo, 0);
    repeat (2) @(posedge clk);
    chk(mosi_sr == exp_mosi, "R1/R2/R3 mosi bytes", mosi_sr, exp_mosi);
    chk(mosi_sr[23:16] == {r, 1'b0, a}, "R1 command", mosi_sr[23:16], {r, 1'b0, a});
    if (r) chk(rdata == pat[15:0], "R3 rdata", rdata, pat[15:0]);
    else   chk(rdata == rprev, "R2 rdata kept", rdata, rprev);
    chk(edges_tot - e0 == 24, "R5 edge count", edges_tot - e0, 24);
    chk(bad_high == 0 && mosi_viol == 0 && min_low >= CLK_DIV, "R4 sclk timing",
        {bad_high[15:0], mosi_viol[15:0]}, 0);
    chk(first_rise_cyc - cs_fall_cyc >= CLK_DIV && cs_rise_cyc - last_fall_cyc >= CLK_DIV
        && sclk_cs_viol == 0, "R5 setup/hold", first_rise_cyc - cs_fall_cyc, CLK_DIV);
    chk(we_tot - w0 == 2, "R6 write count", we_tot - w0, 2);
    chk(mask_val == (irq & 8'hF9), "R6 masked value", mask_val, irq & 8'hF9);
    chk(mask_cyc == cs_fall_cyc - 1 && mask_cyc == busy_rise_cyc, "R6 mask timing", mask_cyc, cs_fall_cyc - 1);
    chk(restore_val == irq, "R6 restored value", restore_val, irq);
    chk(restore_cyc == cs_rise_cyc, "R6 restore timing", restore_cyc, cs_rise_cyc);
    chk(done_tot - d0 == 1 && done_cyc == cs_rise_cyc + 1, "R7 done timing", done_cyc, cs_rise_cyc + 1);
    chk(busy_tot - b0 == done_cyc - busy_rise_cyc + 1 && !busy, "R7 busy span",
        busy_tot - b0, done_cyc - busy_rise_cyc + 1);
    if (poke) begin
      repeat (10) @(posedge clk);
      chk(edges_tot - e0 == 24 && !busy && cs_n, "R8 request while busy ignored", edges_tot - e0, 24);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !we && rdata == 0, "R9 reset state",
        {cs_n, sclk, busy, done, we}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_n && !busy && !we, "R9 idle after reset", {cs_n, busy, we}, 3'b100);
    // directed corners
    run_txn(1'b0, 6'h3F, 16'hA55A, 8'hFF, 24'h123456, 0);   // R2 write, all irq bits set
    run_txn(1'b1, 6'h00, 16'h0000, 8'h00, 24'hFFFFFF, 0);   // R3 read all ones
    run_txn(1'b1, 6'h2A, 16'hFFFF, 8'h06, 24'hFF0000, 0);   // R3 read zeros, cmd byte junk
    run_txn(1'b0, 6'h15, 16'h0000, 8'hF9, 24'h00FFFF, 0);   // R2 write zeros
    run_txn(1'b1, 6'h11, 16'h1234, 8'h5A, 24'h00BEEF, 1);   // R8 poke during read
    run_txn(1'b0, 6'h22, 16'h8001, 8'hA5, 24'h0F0F0F, 1);   // R8 poke during write
    for (int i = 0; i < 40; i++) begin
      run_txn(1'($urandom), 6'($urandom), 16'($urandom), 8'($urandom), 24'($urandom), ($urandom % 8) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule